// File: doc/BRIEF.md
# Chainable SPI Shift-Register Slave

This block is an SPI slave that holds one shift register, WIDTH bits wide, and puts the bit that falls out of that register on its serial output. Several copies can be linked so that each serial output drives the serial input of the next copy. The chip-select and serial clock lines go to every copy in parallel. The linked copies then act as one long shift register. The master reads the serial output of the last copy. A frame of N·WIDTH bits sent in this way places the first word in the copy furthest from the master and the last word in the nearest copy.

The block has a parallel output register, for example to drive a row of LEDs. This register loads the shifted word when chip-select is released and keeps its value while a frame is in progress. The clock polarity and clock phase are parameters and must match the master. The serial inputs are brought into the system clock domain through a synchronizer, and both serial-clock edges are detected in that domain. For this reason the serial-clock half period must be several system clocks long.

Top module: `spi_chain_slave`

## Requirements
- R1: After reset, `pout` is all zeros, the shift register is all zeros and `sdo` is 0. The first frame after reset therefore returns only zero bits to the master.
- R2: The mode is encoded as mode = CPOL·2 + CPHA. The idle level of `sclk` equals CPOL. The leading edge is the edge that leaves the idle level. When CPHA=0, `sdi` is sampled on the leading edge. When CPHA=1, `sdi` is sampled on the trailing edge. Bits move most significant bit first.
- R3: `sdo` changes only on the edge that does not sample. In CPHA=0 it also changes when chip-select is asserted, so that the first bit is ready before the first edge. Each bit on `sdo` is the bit that `sdi` carried exactly WIDTH bit periods earlier.
- R4: Three linked copies form one 24-bit register. After one frame, the copy furthest from the master holds the first byte sent and the nearest copy holds the last byte. The next frame returns the previous frame to the master unchanged.
- R5: `pout` loads the shift register contents when `cs_n` rises.
- R6: While `cs_n` is low, `pout` keeps its previous value.
- R7: While `cs_n` is high, `sclk` and `sdi` have no effect, and `sdo` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip-select, shared by the whole chain |
| sdi | input | 1 | Serial data in (from the master or the previous copy) |
| sdo | output | 1 | Serial data out (to the next copy or to the master) |
| pout | output | WIDTH | Parallel output word, updated when chip-select is released |

## Verification
The hardest case to reach from the ports is the bit-exact delay through a chain: a bit that enters the first copy must leave the third copy exactly 24 bit periods later. The bench links three copies, fills them with one 24-bit frame and sends a second frame. Every bit it reads back during the second frame must equal the first frame in order. The bench also reads `pout` of all three copies in the middle of the second frame. The ignored-clock case follows a completed frame: the bench toggles the serial clock and data while chip-select is high, then checks that `sdo` and `pout` have not moved. It then checks that the next frame still returns the word held before the toggling.

// File: rtl/spi_chain_slave.sv
module spi_chain_slave #(
  parameter int WIDTH = 8,
  parameter int CPOL  = 0,
  parameter int CPHA  = 0,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             sdi,
  output logic             sdo,
  output logic [WIDTH-1:0] pout
);
  localparam int   PIPE = SYNC + 1;
  localparam logic IDLE = (CPOL != 0);

  logic [PIPE-1:0]  sclk_p, cs_p, sdi_p;
  logic [WIDTH-1:0] sreg;
  logic             sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= {PIPE{IDLE}};
      cs_p   <= '1;
      sdi_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[PIPE-2:0], sclk};
      cs_p   <= {cs_p[PIPE-2:0], cs_n};
      sdi_p  <= {sdi_p[PIPE-2:0], sdi};
    end
  end

  wire sclk_now = sclk_p[PIPE-2];
  wire sclk_old = sclk_p[PIPE-1];
  wire cs_now   = cs_p[PIPE-2];
  wire cs_old   = cs_p[PIPE-1];
  wire sdi_now  = sdi_p[PIPE-2];

  wire toggled  = !cs_now && (sclk_now != sclk_old);
  wire lead_ev  = toggled && (sclk_now != IDLE);
  wire trail_ev = toggled && (sclk_now == IDLE);
  wire samp_ev  = (CPHA != 0) ? trail_ev : lead_ev;
  wire shft_ev  = (CPHA != 0) ? lead_ev  : trail_ev;
  wire cs_fall  = cs_old && !cs_now;
  wire cs_rise  = !cs_old && cs_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '0;
      sdo_q <= 1'b0;
      pout  <= '0;
    end else begin
      if (samp_ev)           sreg  <= {sreg[WIDTH-2:0], sdi_now};
      if (cs_fall || shft_ev) sdo_q <= sreg[WIDTH-1];
      if (cs_rise)           pout  <= sreg;
    end
  end

  assign sdo = sdo_q;
endmodule

// File: rtl/spi_chain_slave_chk.sv
module spi_chain_slave_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_now,
  input logic             cs_rise,
  input logic             cs_fall,
  input logic             samp_ev,
  input logic             shft_ev,
  input logic [WIDTH-1:0] sreg,
  input logic             sdo,
  input logic [WIDTH-1:0] pout
);
  a_r2_sreg_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sreg) |-> $past(samp_ev));

  a_r3_sdo_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(shft_ev || cs_fall));

  a_r5_pout_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pout) |-> $past(cs_rise));

  a_r6_pout_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_now && !$past(cs_now)) |-> $stable(pout));

  a_r7_sdo_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_now && $past(cs_now)) |-> $stable(sdo));

  a_r7_sreg_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_now && $past(cs_now)) |-> $stable(sreg));
endmodule

bind spi_chain_slave spi_chain_slave_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_now(cs_now), .cs_rise(cs_rise),
  .cs_fall(cs_fall), .samp_ev(samp_ev), .shft_ev(shft_ev),
  .sreg(sreg), .sdo(sdo), .pout(pout)
);

// File: tb/spi_chain_slave_tb_top.sv
module spi_chain_slave_tb_top;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] sclk_b = 4'b1100;
  logic [3:0] cs_b   = 4'b1111;
  logic [3:0] sdi_b  = 4'b0000;
  logic [3:0] miso;
  logic [23:0] pv [4];

  logic       c01, c12;
  logic [7:0] p0, p1, p2;

  spi_chain_slave #(.CPOL(0), .CPHA(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk_b[0]), .cs_n(cs_b[0]),
    .sdi(sdi_b[0]), .sdo(c01), .pout(p0));
  spi_chain_slave #(.CPOL(0), .CPHA(0)) dut_1 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk_b[0]), .cs_n(cs_b[0]),
    .sdi(c01), .sdo(c12), .pout(p1));
  spi_chain_slave #(.CPOL(0), .CPHA(0)) dut_2 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk_b[0]), .cs_n(cs_b[0]),
    .sdi(c12), .sdo(miso[0]), .pout(p2));
  assign pv[0] = {p2, p1, p0};

  for (genvar m = 1; m < 4; m++) begin : g_mode
    logic [7:0] pm;
    spi_chain_slave #(.CPOL(m / 2), .CPHA(m % 2)) dut_m (
      .clk(clk), .rst_n(rst_n), .sclk(sclk_b[m]), .cs_n(cs_b[m]),
      .sdi(sdi_b[m]), .sdo(miso[m]), .pout(pm));
    assign pv[m] = {16'h0, pm};
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [23:0] exp_q[$];
  logic [23:0] obs_q[$];
  string       tag_q[$];

  task automatic expect_val(input string tag, input logic [23:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic observe(input logic [23:0] v);
    obs_q.push_back(v);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0 && obs_q.size() > 0) begin
      logic [23:0] e, o;
      string t;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (o !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, o, e);
      end
    end
  end

  task automatic xfer(input int m, input logic [23:0] tx, input int n,
                      output logic [23:0] rx, output logic [23:0] mid);
    logic pol, pha;
    pol = m[1];
    pha = m[0];
    rx  = '0;
    mid = '0;
    @(negedge clk);
    cs_b[m] = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      if (!pha) begin
        sdi_b[m] = tx[i];
        repeat (H) @(negedge clk);
        rx = {rx[22:0], miso[m]};
        sclk_b[m] = ~pol;
        repeat (H) @(negedge clk);
        sclk_b[m] = pol;
      end else begin
        sclk_b[m] = ~pol;
        sdi_b[m] = tx[i];
        repeat (H) @(negedge clk);
        rx = {rx[22:0], miso[m]};
        sclk_b[m] = pol;
        repeat (H) @(negedge clk);
      end
      if (i == n / 2) mid = pv[m];
    end
    repeat (H) @(negedge clk);
    cs_b[m] = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] rx, mid, hold_p;
    logic hold_o;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int m = 0; m < 4; m++) begin
      expect_val("R1 pout reset", 24'h0); observe(pv[m]);
      expect_val("R1 sdo reset", 24'h0);  observe({23'h0, miso[m]});
    end

    xfer(0, 24'hA53CE1, 24, rx, mid);
    expect_val("R1 first frame zeros", 24'h0); observe(rx);
    expect_val("R4 far end first byte", 24'hA53CE1); observe(pv[0]);
    xfer(0, 24'h5AC31E, 24, rx, mid);
    expect_val("R6 pout hold mid frame", 24'hA53CE1); observe(mid);
    expect_val("R3 R4 chain delay 24 bits", 24'hA53CE1); observe(rx);
    expect_val("R5 chain load on release", 24'h5AC31E); observe(pv[0]);

    for (int m = 1; m < 4; m++) begin
      logic [7:0] a, b;
      a = 8'h96 ^ 8'(m * 8'h11);
      b = 8'h3D + 8'(m * 8'h23);
      xfer(m, {16'h0, a}, 8, rx, mid);
      expect_val("R2 mode first frame", 24'h0); observe(rx);
      expect_val("R2 R5 mode load", {16'h0, a}); observe(pv[m]);
      xfer(m, {16'h0, b}, 8, rx, mid);
      expect_val("R6 mode hold mid", {16'h0, a}); observe(mid);
      expect_val("R3 mode returns previous", {16'h0, a}); observe(rx);
      expect_val("R5 mode second load", {16'h0, b}); observe(pv[m]);
    end

    hold_o = miso[3];
    hold_p = pv[3];
    for (int k = 0; k < 16; k++) begin
      sclk_b[3] = ~sclk_b[3];
      sdi_b[3]  = k[0];
      repeat (H) @(negedge clk);
    end
    sclk_b[3] = 1'b1;
    repeat (H) @(negedge clk);
    expect_val("R7 sdo hold idle", {23'h0, hold_o}); observe({23'h0, miso[3]});
    expect_val("R7 pout untouched", hold_p); observe(pv[3]);
    xfer(3, 24'h0000C7, 8, rx, mid);
    expect_val("R7 sreg untouched by idle clocks", hold_p); observe(rx);
    expect_val("R5 load after idle clocks", 24'h0000C7); observe(pv[3]);

    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule